// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block steps a small display panel through its four power phases: bring-up, display enable, display disable and shutdown. Each phase starts on a one-cycle request strobe. The block then issues an ordered series of register writes through a serial command writer's request/response interface. Between writes it may wait a timed gap, and it switches a backlight-enable output at a fixed point in the phase. The bring-up and shutdown write lists live in a small internal step table. Each table entry holds a register address, a payload length and a 16-bit value, and the list ends with a terminator entry.

A power controller drives the strobes and watches `ready`, `done` and `fail`. The serial writer accepts a request on `cmd_valid`/`cmd_ready` and later answers with a one-cycle `rsp_done` that carries `rsp_err`. Bring-up starts by waking the panel with three empty commands, each followed by a wake gap. It stops at the first write that fails. Shutdown and disable push every write through whatever the writer answers. Enable and disable mirror each other: the backlight goes on only after the display-on write succeeds, and it goes off before the display-off write is offered.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `ready` is 1 and `backlight_en`, `cmd_valid` and `done` are 0.
- R2: Bring-up first issues three writes with address 0x00 and length 0. After the response to each of them, no further write is offered for at least `WAKE_CYCLES` clock cycles.
- R3: After the wake writes, bring-up issues these writes, listed as address/length/value: 0xB0/1/0x17, 0xBC/1/0x80, 0x3B/1/0x00, 0xB0/1/0x16, 0xB8/2/0xFFF9, 0x11/0/-. Length codes are 0 (no payload), 1 (one byte in `cmd_data[7:0]`) and 2 (two bytes, high byte first on the wire).
- R4: Bring-up then issues 34 tuning writes from the table, the last being 0xD5/1/0x0E, for 43 writes in all. It ends with `done` and `fail`=0.
- R5: During bring-up, a write answered with `rsp_err`=1 is the last write issued. The phase ends with `done` and `fail`=1.
- R6: Enable issues 0x29/0. `backlight_en` rises in the cycle after a successful response. On an error response, `backlight_en` stays 0 and the phase ends with `fail`=1.
- R7: Disable drops `backlight_en` in the cycle after the strobe is taken, before 0x28/0 is offered. The write is issued even if it fails, and the phase ends with `fail`=0.
- R8: Shutdown issues 0xB8/2/0x8002, then 0x10/0, then 0xB0/1/0x00. Every write is issued even when each one fails, and the phase ends with `fail`=0.
- R9: A request strobe while `ready`=0 is ignored: it causes no write and no backlight change.
- R10: When several strobes arrive together while ready, only one phase runs, chosen by the priority bring-up > enable > disable > shutdown.
- R11: While `cmd_valid`=1 and `cmd_ready`=0, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_data` hold steady.
- R12: `done` is a one-cycle pulse, and `ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_prepare | input | 1 | Bring-up phase strobe |
| req_enable | input | 1 | Display enable phase strobe |
| req_disable | input | 1 | Display disable phase strobe |
| req_unprepare | input | 1 | Shutdown phase strobe |
| cmd_valid | output | 1 | Write request to the serial writer |
| cmd_ready | input | 1 | Writer accepts the request |
| cmd_addr | output | 8 | Register/command address |
| cmd_len | output | 2 | Payload length code (0, 1, 2) |
| cmd_data | output | 16 | Payload value |
| rsp_done | input | 1 | Writer finished the accepted write |
| rsp_err | input | 1 | That write failed (valid with rsp_done) |
| backlight_en | output | 1 | Backlight enable |
| ready | output | 1 | Idle, a strobe will be taken |
| done | output | 1 | Phase finished (one cycle) |
| fail | output | 1 | Phase finished with an error (with done) |

## Verification
A new phase strobe can land in the same cycle as work that another phase is still doing, and several strobes can land in the same cycle as each other. The bench pulses enable partway through a disable phase. It also raises enable with shutdown, and disable with shutdown, in one cycle. A behavioural model holds the expected write queue and the expected backlight level, and it is compared on every clock. Any write the queue does not expect counts as a failure, and so does a backlight level that differs from the model in any cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

   localparam int REG_W = 8;
   localparam int VAL_W = 16;
   localparam int LEN_W = 2;

   localparam logic [LEN_W-1:0] LEN_NONE = 2'd0;
   localparam logic [LEN_W-1:0] LEN_BYTE = 2'd1;
   localparam logic [LEN_W-1:0] LEN_WORD = 2'd2;
   localparam logic [LEN_W-1:0] LEN_END  = 2'd3;

   localparam int LIST_DEPTH  = 45;
   localparam int LIST_IW     = $clog2(LIST_DEPTH);
   localparam int PREP_BASE   = 0;
   localparam int UNPREP_BASE = 41;

   localparam logic [REG_W-1:0] OP_WAKE     = 8'h00;
   localparam logic [REG_W-1:0] OP_SHOW     = 8'h29;
   localparam logic [REG_W-1:0] OP_HIDE     = 8'h28;

   typedef struct packed {
      logic [REG_W-1:0] reg_a;
      logic [LEN_W-1:0] len;
      logic [VAL_W-1:0] val;
   } step_t;

   function automatic step_t mk_step(input logic [REG_W-1:0] a,
                                     input logic [LEN_W-1:0] l,
                                     input logic [VAL_W-1:0] v);
      step_t s;
      s.reg_a = a;
      s.len   = l;
      s.val   = v;
      return s;
   endfunction

endpackage

// File: rtl/pps_step_rom.sv
module pps_step_rom
   import pps_pkg::*;
#(
   parameter int IW = LIST_IW
) (
   input  logic [IW-1:0] idx,
   output step_t         step
);

   always_comb begin
      case (int'(idx))
         // bring-up list
         0:  step = mk_step(8'hB0, LEN_BYTE, 16'h0017);
         1:  step = mk_step(8'hBC, LEN_BYTE, 16'h0080);
         2:  step = mk_step(8'h3B, LEN_BYTE, 16'h0000);
         3:  step = mk_step(8'hB0, LEN_BYTE, 16'h0016);
         4:  step = mk_step(8'hB8, LEN_WORD, 16'hFFF9);
         5:  step = mk_step(8'h11, LEN_NONE, 16'h0000);
         6:  step = mk_step(8'hBA, LEN_BYTE, 16'h0001);
         7:  step = mk_step(8'hBB, LEN_BYTE, 16'h0000);
         8:  step = mk_step(8'h3A, LEN_BYTE, 16'h0060);
         9:  step = mk_step(8'hBF, LEN_BYTE, 16'h0010);
         10: step = mk_step(8'hB1, LEN_BYTE, 16'h0056);
         11: step = mk_step(8'hB2, LEN_BYTE, 16'h0033);
         12: step = mk_step(8'hB3, LEN_BYTE, 16'h0011);
         13: step = mk_step(8'hB3, LEN_BYTE, 16'h0011);
         14: step = mk_step(8'hB4, LEN_BYTE, 16'h0002);
         15: step = mk_step(8'hB5, LEN_BYTE, 16'h002B);
         16: step = mk_step(8'hB6, LEN_BYTE, 16'h0040);
         17: step = mk_step(8'hB7, LEN_BYTE, 16'h0003);
         18: step = mk_step(8'hB9, LEN_BYTE, 16'h0004);
         19: step = mk_step(8'hBD, LEN_BYTE, 16'h0004);
         20: step = mk_step(8'hBE, LEN_BYTE, 16'h0000);
         21: step = mk_step(8'hC0, LEN_BYTE, 16'h0011);
         22: step = mk_step(8'hC1, LEN_BYTE, 16'h0011);
         23: step = mk_step(8'hC2, LEN_BYTE, 16'h0011);
         24: step = mk_step(8'hC3, LEN_WORD, 16'h2040);
         25: step = mk_step(8'hC4, LEN_WORD, 16'h60C0);
         26: step = mk_step(8'hC5, LEN_WORD, 16'h1020);
         27: step = mk_step(8'hC6, LEN_WORD, 16'h60C0);
         28: step = mk_step(8'hC7, LEN_WORD, 16'h5533);
         29: step = mk_step(8'hC8, LEN_BYTE, 16'h0000);
         30: step = mk_step(8'hC9, LEN_BYTE, 16'h0000);
         31: step = mk_step(8'hCA, LEN_BYTE, 16'h0000);
         32: step = mk_step(8'hEC, LEN_WORD, 16'h01F0);
         33: step = mk_step(8'hCF, LEN_BYTE, 16'h0002);
         34: step = mk_step(8'hD0, LEN_WORD, 16'h0804);
         35: step = mk_step(8'hD1, LEN_BYTE, 16'h0001);
         36: step = mk_step(8'hD2, LEN_WORD, 16'h0000);
         37: step = mk_step(8'hD3, LEN_WORD, 16'h0D0E);
         38: step = mk_step(8'hD4, LEN_WORD, 16'h11A4);
         39: step = mk_step(8'hD5, LEN_BYTE, 16'h000E);
         // 40: terminator (default)
         // shutdown list
         41: step = mk_step(8'hB8, LEN_WORD, 16'h8002);
         42: step = mk_step(8'h10, LEN_NONE, 16'h0000);
         43: step = mk_step(8'hB0, LEN_BYTE, 16'h0000);
         default: step = mk_step(8'h00, LEN_END, 16'h0000);
      endcase
   end

endmodule

// File: rtl/pps_gap_timer.sv
module pps_gap_timer #(
   parameter int unsigned CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   generate
      if (CYCLES == 0) begin : g_none
         assign expired = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(CYCLES + 1);
         logic [TW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (start)      cnt <= TW'(CYCLES);
            else if (cnt != '0)  cnt <= cnt - TW'(1);
         end

         assign expired = (cnt == '0);

         // wake gap may not end in the cycle right after it starts
         assert_gap_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !expired);
      end
   endgenerate

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
   import pps_pkg::*;
#(
   parameter int unsigned WAKE_CYCLES = 250000,
   parameter int unsigned WAKE_COUNT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_prepare,
   input  logic             req_enable,
   input  logic             req_disable,
   input  logic             req_unprepare,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic [REG_W-1:0] cmd_addr,
   output logic [LEN_W-1:0] cmd_len,
   output logic [VAL_W-1:0] cmd_data,
   input  logic             rsp_done,
   input  logic             rsp_err,
   output logic             backlight_en,
   output logic             ready,
   output logic             done,
   output logic             fail
);

   localparam int NW = $clog2(WAKE_COUNT + 1);

   typedef enum logic [3:0] {
      S_IDLE, S_WAKE_REQ, S_WAKE_RSP, S_WAKE_GAP,
      S_LIST_REQ, S_LIST_RSP, S_ON_REQ, S_ON_RSP,
      S_OFF_REQ, S_OFF_RSP, S_DONE
   } st_e;

   st_e               st;
   logic [LIST_IW-1:0] idx;
   logic [NW-1:0]     nop_n;
   logic              strict_q;
   logic              err_q;
   logic              bl_q;
   logic              gap_start;
   logic              gap_over;
   step_t             step;

   pps_step_rom #(.IW(LIST_IW)) u_rom (
      .idx  (idx),
      .step (step)
   );

   pps_gap_timer #(.CYCLES(WAKE_CYCLES)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (gap_start),
      .expired (gap_over)
   );

   wire list_end = (step.len == LEN_END);

   assign gap_start = (st == S_WAKE_RSP) && rsp_done && !rsp_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         idx      <= '0;
         nop_n    <= '0;
         strict_q <= 1'b0;
         err_q    <= 1'b0;
         bl_q     <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               err_q <= 1'b0;
               if (req_prepare) begin
                  st       <= S_WAKE_REQ;
                  nop_n    <= '0;
                  strict_q <= 1'b1;
               end else if (req_enable) begin
                  st <= S_ON_REQ;
               end else if (req_disable) begin
                  bl_q <= 1'b0;
                  st   <= S_OFF_REQ;
               end else if (req_unprepare) begin
                  idx      <= LIST_IW'(UNPREP_BASE);
                  strict_q <= 1'b0;
                  st       <= S_LIST_REQ;
               end
            end
            S_WAKE_REQ: if (cmd_ready) st <= S_WAKE_RSP;
            S_WAKE_RSP: if (rsp_done) begin
               if (rsp_err) begin
                  err_q <= 1'b1;
                  st    <= S_DONE;
               end else begin
                  nop_n <= nop_n + NW'(1);
                  st    <= S_WAKE_GAP;
               end
            end
            S_WAKE_GAP: if (gap_over) begin
               if (nop_n == NW'(WAKE_COUNT)) begin
                  idx <= LIST_IW'(PREP_BASE);
                  st  <= S_LIST_REQ;
               end else begin
                  st  <= S_WAKE_REQ;
               end
            end
            S_LIST_REQ: begin
               if (list_end)       st <= S_DONE;
               else if (cmd_ready) st <= S_LIST_RSP;
            end
            S_LIST_RSP: if (rsp_done) begin
               if (rsp_err && strict_q) begin
                  err_q <= 1'b1;
                  st    <= S_DONE;
               end else begin
                  idx <= idx + LIST_IW'(1);
                  st  <= S_LIST_REQ;
               end
            end
            S_ON_REQ: if (cmd_ready) st <= S_ON_RSP;
            S_ON_RSP: if (rsp_done) begin
               if (rsp_err) err_q <= 1'b1;
               else         bl_q  <= 1'b1;
               st <= S_DONE;
            end
            S_OFF_REQ: if (cmd_ready) st <= S_OFF_RSP;
            S_OFF_RSP: if (rsp_done) st <= S_DONE;
            default:   st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_addr  = OP_WAKE;
      cmd_len   = LEN_NONE;
      cmd_data  = '0;
      case (st)
         S_WAKE_REQ: cmd_valid = 1'b1;
         S_LIST_REQ: begin
            cmd_valid = !list_end;
            cmd_addr  = step.reg_a;
            cmd_len   = step.len;
            cmd_data  = step.val;
         end
         S_ON_REQ: begin
            cmd_valid = 1'b1;
            cmd_addr  = OP_SHOW;
         end
         S_OFF_REQ: begin
            cmd_valid = 1'b1;
            cmd_addr  = OP_HIDE;
         end
         default: ;
      endcase
   end

   assign backlight_en = bl_q;
   assign ready        = (st == S_IDLE);
   assign done         = (st == S_DONE);
   assign fail         = (st == S_DONE) && err_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !cmd_valid);

   assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                     && $stable(cmd_len) && $stable(cmd_data)));

   assert_light_after_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backlight_en) |-> $past(rsp_done && !rsp_err));

   assert_dark_before_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_addr == OP_HIDE && cmd_len == LEN_NONE) |-> !backlight_en);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

endmodule

// File: tb/panel_power_seq_bench.sv
module panel_power_seq_bench;

   localparam int W = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic rq_p = 0, rq_e = 0, rq_d = 0, rq_u = 0;
   logic cmd_ready = 0, rsp_done = 0, rsp_err = 0;
   logic cmd_valid, backlight_en, ready, done, fail;
   logic [7:0]  cmd_addr;
   logic [1:0]  cmd_len;
   logic [15:0] cmd_data;

   panel_power_seq #(.WAKE_CYCLES(W)) u_panel_power_seq (
      .clk(clk), .rst_n(rst_n),
      .req_prepare(rq_p), .req_enable(rq_e), .req_disable(rq_d), .req_unprepare(rq_u),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_data(cmd_data), .rsp_done(rsp_done), .rsp_err(rsp_err),
      .backlight_en(backlight_en), .ready(ready), .done(done), .fail(fail)
   );

   int total = 0, bad = 0, cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [25:0] pk(input logic [7:0] a, input logic [1:0] l, input logic [15:0] v);
      return {a, l, v};
   endfunction

   // reference model state
   logic [25:0] expq[$];
   int          free_n = 0;
   logic [25:0] last_w = '0;
   logic [25:0] prev_cmd = '0;
   bit          prev_stall = 0;
   int          err_at = -1;
   bit          err_all = 0;
   int          ph_wr = 0;
   int          rsp_wait = 0;
   int          gap_ref = -1;
   int          bp = 0;
   bit          bl_exp = 0;
   string       ph_tag = "R1";

   always @(negedge clk) begin
      logic [25:0] cur;
      cyc++;
      cur = {cmd_addr, cmd_len, cmd_data};
      if (rst_n) begin
         chk(backlight_en == bl_exp, "R6 R7 R9 backlight level", backlight_en, bl_exp);
         if (prev_stall)
            chk(cmd_valid && cur == prev_cmd, "R11 held request", cur, prev_cmd);
         rsp_done = 0;
         rsp_err  = 0;
         if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
               rsp_done = 1;
               rsp_err  = err_all || (ph_wr - 1 == err_at);
               if (!rsp_err && last_w[25:18] == 8'h29) bl_exp = 1;
               if (last_w[25:18] == 8'h00) gap_ref = cyc;
            end
         end
         if (rq_d && ready && !rq_p && !rq_e) bl_exp = 0;
         bp++;
         cmd_ready = (bp % 3) != 0;
         if (cmd_valid && cmd_ready) begin
            last_w = cur;
            ph_wr++;
            rsp_wait = 2;
            if (gap_ref >= 0) begin
               chk(cyc - gap_ref >= W, "R2 wake gap", cyc - gap_ref, W);
               gap_ref = -1;
            end
            if (expq.size() > 0) begin
               logic [25:0] e;
               e = expq.pop_front();
               chk(cur == e, ph_tag, cur, e);
            end else if (free_n > 0) begin
               free_n--;
            end else begin
               chk(0, "R9 R10 unexpected write", cur, 0);
            end
         end
         prev_stall = cmd_valid && !cmd_ready;
         prev_cmd   = cur;
      end
   end

   task automatic run(input bit p, input bit e, input bit d, input bit u,
                      input int ea, input bit eall, input bit late_en,
                      input bit exp_fail, input string tag);
      int n;
      @(posedge clk); #1;
      err_at = ea; err_all = eall; ph_wr = 0; gap_ref = -1; ph_tag = tag;
      rq_p = p; rq_e = e; rq_d = d; rq_u = u;
      @(posedge clk); #1;
      rq_p = 0; rq_e = 0; rq_d = 0; rq_u = 0;
      if (late_en) begin
         @(posedge clk); #1; rq_e = 1;
         @(posedge clk); #1; rq_e = 0;
      end
      n = 0;
      while (!done && n < 5000) begin
         @(posedge clk); #1;
         n++;
      end
      chk(done, {tag, " done seen"}, done, 1);
      chk(fail == exp_fail, {tag, " fail flag"}, fail, exp_fail);
      chk(expq.size() == 0 && free_n == 0, {tag, " all writes issued"}, expq.size() + free_n, 0);
      @(posedge clk); #1;
      chk(ready && !done, "R12 ready after done pulse", {ready, done}, 2'b10);
      repeat (6) begin
         @(posedge clk); #1;
      end
      chk(!cmd_valid && ready, "R9 no phase after ignored strobe", {cmd_valid, ready}, 2'b01);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1;
      chk(ready && !backlight_en && !cmd_valid && !done, "R1 reset state",
          {ready, backlight_en, cmd_valid, done}, 4'b1000);
      rst_n = 1;

      // R2 R3 R4 full bring-up
      repeat (3) expq.push_back(pk(8'h00, 2'd0, 16'h0000));
      expq.push_back(pk(8'hB0, 2'd1, 16'h0017));
      expq.push_back(pk(8'hBC, 2'd1, 16'h0080));
      expq.push_back(pk(8'h3B, 2'd1, 16'h0000));
      expq.push_back(pk(8'hB0, 2'd1, 16'h0016));
      expq.push_back(pk(8'hB8, 2'd2, 16'hFFF9));
      expq.push_back(pk(8'h11, 2'd0, 16'h0000));
      free_n = 34;
      run(1, 0, 0, 0, -1, 0, 0, 0, "R3 bring-up order");
      chk(ph_wr == 43, "R4 bring-up write count", ph_wr, 43);
      chk(last_w == pk(8'hD5, 2'd1, 16'h000E), "R4 last tuning write", last_w, pk(8'hD5, 2'd1, 16'h000E));

      // R6 enable
      expq.push_back(pk(8'h29, 2'd0, 16'h0000));
      run(0, 1, 0, 0, -1, 0, 0, 0, "R6 enable write");
      chk(backlight_en, "R6 backlight on", backlight_en, 1);

      // R7 R9 disable with a strobe during the phase
      expq.push_back(pk(8'h28, 2'd0, 16'h0000));
      run(0, 0, 1, 0, -1, 0, 1, 0, "R7 disable write");
      chk(!backlight_en, "R9 late enable ignored", backlight_en, 0);

      // R7 disable write fails, still ends without fail
      expq.push_back(pk(8'h29, 2'd0, 16'h0000));
      run(0, 1, 0, 0, -1, 0, 0, 0, "R6 enable write");
      expq.push_back(pk(8'h28, 2'd0, 16'h0000));
      run(0, 0, 1, 0, 0, 0, 0, 0, "R7 disable on error");

      // R8 shutdown with every write failing
      expq.push_back(pk(8'hB8, 2'd2, 16'h8002));
      expq.push_back(pk(8'h10, 2'd0, 16'h0000));
      expq.push_back(pk(8'hB0, 2'd1, 16'h0000));
      run(0, 0, 0, 1, -1, 1, 0, 0, "R8 shutdown order");
      chk(ph_wr == 3, "R8 shutdown write count", ph_wr, 3);

      // R10 simultaneous strobes
      expq.push_back(pk(8'h29, 2'd0, 16'h0000));
      run(0, 1, 0, 1, -1, 0, 0, 0, "R10 enable beats shutdown");
      expq.push_back(pk(8'h28, 2'd0, 16'h0000));
      run(0, 0, 1, 1, -1, 0, 0, 0, "R10 disable beats shutdown");

      // R5 bring-up stops at first failing write (index 4)
      repeat (3) expq.push_back(pk(8'h00, 2'd0, 16'h0000));
      expq.push_back(pk(8'hB0, 2'd1, 16'h0017));
      expq.push_back(pk(8'hBC, 2'd1, 16'h0080));
      run(1, 0, 0, 0, 4, 0, 0, 1, "R5 bring-up stop");
      chk(ph_wr == 5, "R5 writes before stop", ph_wr, 5);

      // R6 enable write fails
      expq.push_back(pk(8'h29, 2'd0, 16'h0000));
      run(0, 1, 0, 0, 0, 0, 0, 1, "R6 enable on error");
      chk(!backlight_en, "R6 backlight stays off", backlight_en, 0);

      summary();
   end

endmodule